// File: doc/BRIEF.md
# Software-Driven SPI Pin Controller

This block is a small register-mapped unit that lets software run an SPI link one pin transition at a time. A request channel carries 32-bit reads and writes to four word-aligned registers: a mode register, a plain scratch control register, a pin register and a receive register. Whenever bit 0 of the mode register is set, the serial clock, the data output and three chip-select pins take their levels straight from the pin register. Otherwise the pins are handed to a separate memory-mapped flash read engine through a set of pass-through inputs.

To clock out a word in SPI mode 0, software writes the pin register with the clock low and the next data bit, then writes it again with the clock high. The words go out MSB first and may be 1 to 32 bits long. Each write that raises the clock bit while software mode is on also captures the synchronized MISO input into bit 0 of a 32-bit receive shift register. Older bits move toward the MSB. Once the word is finished, reading that register returns the received bits, with the latest bit in bit 0.

The bus side is a valid/ready request channel paired with a valid/ready response channel. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. Every accepted read produces exactly one response and a write produces none. A response stays on the channel unchanged until `rsp_ready` takes it. While a response is waiting and `rsp_ready` is low, `req_ready` is low. This gives the response side direct back-pressure on new requests.

Top module: `spi_pin_ctrl`

## Requirements
- R1: Byte offsets 0x00 (mode), 0x04 (control), 0x08 (pin) and 0x0C (receive) are the only mapped addresses. A read of any other offset, including a misaligned one with address bits [1:0] not zero, returns 0. A write to such an offset changes no register.
- R2: After reset every register reads 0, no response is pending, and the pins follow the flash engine inputs.
- R3: While mode bit 0 is 1, `spi_mosi` equals pin-register bit 0, `spi_sck` equals bit 8 and `spi_cs[n]` equals bit 16+n for n = 0..2, with no inversion.
- R4: While mode bit 0 is 0, `spi_sck`, `spi_mosi` and `spi_cs` equal `fe_sck`, `fe_mosi` and `fe_cs`, whatever the pin register holds.
- R5: The mode, control and pin registers store and return all 32 bits last written to them.
- R6: A pin-register write that takes bit 8 from 0 to 1 while mode bit 0 is 1 shifts the receive register left by one. The synchronized MISO value enters bit 0 and the old bit 31 is lost.
- R7: No other write shifts the receive register. This covers a write that keeps bit 8 low, one that keeps it high, and a rising write while mode bit 0 is 0.
- R8: MISO passes through a two-flop synchronizer. A rising write accepted on the second clock edge after MISO changes captures the old level. A rising write accepted on the third edge or later captures the new level.
- R9: The receive register is read-only, and writes to 0x0C leave it unchanged.
- R10: A pending response holds `rsp_valid` and `rsp_data` unchanged until `rsp_ready` is high. `req_ready` is low while a response is pending and `rsp_ready` is low. Writes produce no response.
- R11: A read accepted on a clock edge raises `rsp_valid` after that same edge, carrying the register value from before any write in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Read data taken |
| rsp_data | output | DATA_W | Read data |
| fe_sck | input | 1 | Flash engine clock, used when software mode is off |
| fe_mosi | input | 1 | Flash engine data out |
| fe_cs | input | NUM_CS | Flash engine chip selects |
| spi_sck | output | 1 | Serial clock pin |
| spi_mosi | output | 1 | Serial data out pin |
| spi_cs | output | NUM_CS | Chip-select pins |
| spi_miso | input | 1 | Serial data in pin, asynchronous |

## Verification
The assertions take for granted that the request fields do not change while a request waits for `req_ready`. They also assume that `rsp_ready` is a clean level sampled on the clock edge, and that MISO meets the synchronizer's setup only through its two flops. The stimulus changes MISO and then waits at least two idle cycles before it raises the clock, except in the one directed case that probes the synchronizer depth. It drives every request and ready change half a cycle away from the sampling edge. Random words of random length and random pin patterns are mixed with directed cases: a clock that is already high, a rise with software mode off, writes to the receive register and to unmapped or misaligned offsets, and a response held back for several cycles.

// File: rtl/spi_pin_ctrl_pkg.sv
package spi_pin_ctrl_pkg;
  // register word index (byte offset / 4)
  localparam int IDX_MODE = 0;
  localparam int IDX_CTRL = 1;
  localparam int IDX_PIN  = 2;
  localparam int IDX_RX   = 3;

  // pin register field positions
  localparam int PIN_MOSI_BIT = 0;
  localparam int PIN_SCK_BIT  = 8;
  localparam int PIN_CS_BASE  = 16;
  localparam int MODE_SW_BIT  = 0;

  typedef enum logic [2:0] {
    SEL_MODE,
    SEL_CTRL,
    SEL_PIN,
    SEL_RX,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/spi_pin_ctrl_sync.sv
module spi_pin_ctrl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_pin_ctrl_rxsh.sv
module spi_pin_ctrl_rxsh #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {q[W-2:0], bit_in};
  end
endmodule

// File: rtl/spi_pin_ctrl_pinmux.sv
module spi_pin_ctrl_pinmux #(
  parameter int NUM_CS = 3
) (
  input  logic              sw_mode,
  input  logic              sw_sck,
  input  logic              sw_mosi,
  input  logic [NUM_CS-1:0] sw_cs,
  input  logic              fe_sck,
  input  logic              fe_mosi,
  input  logic [NUM_CS-1:0] fe_cs,
  output logic              pin_sck,
  output logic              pin_mosi,
  output logic [NUM_CS-1:0] pin_cs
);
  assign pin_sck  = sw_mode ? sw_sck  : fe_sck;
  assign pin_mosi = sw_mode ? sw_mosi : fe_mosi;

  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign pin_cs[i] = sw_mode ? sw_cs[i] : fe_cs[i];
    end
  endgenerate
endmodule

// File: rtl/spi_pin_ctrl.sv
module spi_pin_ctrl
  import spi_pin_ctrl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int NUM_CS      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              fe_sck,
  input  logic              fe_mosi,
  input  logic [NUM_CS-1:0] fe_cs,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic [NUM_CS-1:0] spi_cs,
  input  logic              spi_miso
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [DATA_W-1:0] mode_q, ctrl_q, pin_q, rx_q;
  logic [DATA_W-1:0] rd_mux, rsp_data_q;
  logic              rsp_valid_q;
  logic              miso_s;
  reg_sel_e          sel;
  logic              accept, wr_acc, rd_acc, sck_rise;

  // address decode: aligned word index only
  always_comb begin
    sel = SEL_NONE;
    if (req_addr[1:0] == 2'b00) begin
      if      (req_addr[ADDR_W-1:2] == WIDX_W'(IDX_MODE)) sel = SEL_MODE;
      else if (req_addr[ADDR_W-1:2] == WIDX_W'(IDX_CTRL)) sel = SEL_CTRL;
      else if (req_addr[ADDR_W-1:2] == WIDX_W'(IDX_PIN))  sel = SEL_PIN;
      else if (req_addr[ADDR_W-1:2] == WIDX_W'(IDX_RX))   sel = SEL_RX;
    end
  end

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_acc    = accept && req_write;
  assign rd_acc    = accept && !req_write;

  // rising clock bit created by software while it owns the pins
  assign sck_rise = wr_acc && (sel == SEL_PIN) && mode_q[MODE_SW_BIT]
                    && !pin_q[PIN_SCK_BIT] && req_wdata[PIN_SCK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= '0;
      pin_q  <= '0;
    end else if (wr_acc) begin
      case (sel)
        SEL_MODE: mode_q <= req_wdata;
        SEL_CTRL: ctrl_q <= req_wdata;
        SEL_PIN:  pin_q  <= req_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_MODE: rd_mux = mode_q;
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_PIN:  rd_mux = pin_q;
      SEL_RX:   rd_mux = rx_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (rd_acc) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  spi_pin_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (spi_miso),
    .q     (miso_s)
  );

  spi_pin_ctrl_rxsh #(.W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sck_rise),
    .bit_in   (miso_s),
    .q        (rx_q)
  );

  spi_pin_ctrl_pinmux #(.NUM_CS(NUM_CS)) u_mux (
    .sw_mode  (mode_q[MODE_SW_BIT]),
    .sw_sck   (pin_q[PIN_SCK_BIT]),
    .sw_mosi  (pin_q[PIN_MOSI_BIT]),
    .sw_cs    (pin_q[PIN_CS_BASE +: NUM_CS]),
    .fe_sck   (fe_sck),
    .fe_mosi  (fe_mosi),
    .fe_cs    (fe_cs),
    .pin_sck  (spi_sck),
    .pin_mosi (spi_mosi),
    .pin_cs   (spi_cs)
  );
endmodule

// File: rtl/spi_pin_ctrl_chk.sv
module spi_pin_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int WIDX_W = 6,
  parameter int NUM_CS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [WIDX_W-1:0] addr_word,
  input logic [1:0]        addr_low,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic [NUM_CS-1:0] spi_cs,
  input logic              mode_sw,
  input logic              pin_sck,
  input logic              miso_s,
  input logic [DATA_W-1:0] rx_q
);
  logic pin_wr, rise_c, rd_c;
  assign pin_wr = req_valid && req_ready && req_write && addr_low == 2'b00
                  && addr_word == WIDX_W'(2);
  assign rise_c = pin_wr && mode_sw && !pin_sck && req_wdata[8];
  assign rd_c   = req_valid && req_ready && !req_write;

  // R3
  pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_wr && mode_sw |=> spi_sck == $past(req_wdata[8]) && spi_mosi == $past(req_wdata[0])
                          && spi_cs == $past(req_wdata[16 +: NUM_CS]));
  // R6
  rx_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_c |=> rx_q[DATA_W-1:1] == $past(rx_q[DATA_W-2:0]) && rx_q[0] == $past(miso_s));
  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_c |=> $stable(rx_q));
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R10
  req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_c |=> rsp_valid);
endmodule

bind spi_pin_ctrl spi_pin_ctrl_chk #(
  .DATA_W (DATA_W),
  .WIDX_W (ADDR_W - 2),
  .NUM_CS (NUM_CS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .addr_word (req_addr[ADDR_W-1:2]),
  .addr_low  (req_addr[1:0]),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .spi_sck   (spi_sck),
  .spi_mosi  (spi_mosi),
  .spi_cs    (spi_cs),
  .mode_sw   (mode_q[0]),
  .pin_sck   (pin_q[8]),
  .miso_s    (miso_s),
  .rx_q      (rx_q)
);

// File: tb/sim_spi_pin_ctrl.sv
`timescale 1ns/1ps
module sim_spi_pin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic        fe_sck = 1'b0, fe_mosi = 1'b0, spi_miso = 1'b0;
  logic [2:0]  fe_cs = '0;
  logic        spi_sck, spi_mosi;
  logic [2:0]  spi_cs;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] mode_m = '0, ctrl_m = '0, pin_m = '0, rx_m = '0;

  always #2.5 clk = ~clk;

  spi_pin_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .fe_sck(fe_sck), .fe_mosi(fe_mosi), .fe_cs(fe_cs),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs(spi_cs), .spi_miso(spi_miso));

  function automatic logic [4:0] pins_exp();
    if (mode_m[0]) return {pin_m[18:16], pin_m[8], pin_m[0]};
    return {fe_cs, fe_sck, fe_mosi};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_pins(input string req);
    chk(req, {27'd0, spi_cs, spi_sck, spi_mosi}, {27'd0, pins_exp()});
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pin_wr(input logic [31:0] v);
    if (mode_m[0] && !pin_m[8] && v[8]) rx_m = {rx_m[30:0], spi_miso};
    pin_m = v;
    wr(8'h08, v);
  endtask

  task automatic set_miso(input logic b);
    spi_miso = b;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, word, got;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk("R2 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk_pins("R2 pins");
    rd_chk("R2 mode", 8'h00, 0);
    rd_chk("R2 ctrl", 8'h04, 0);
    rd_chk("R2 pin", 8'h08, 0);
    rd_chk("R2 rx", 8'h0C, 0);

    // R4 flash engine owns pins
    pin_wr(32'h0007_0101);
    for (int i = 0; i < 8; i++) begin
      {fe_cs, fe_sck, fe_mosi} = 5'($urandom);
      #1;
      chk_pins("R4 fe passthrough");
    end

    // R5 storage
    for (int i = 0; i < 4; i++) begin
      ctrl_m = $urandom;
      wr(8'h04, ctrl_m);
      rd_chk("R5 ctrl", 8'h04, ctrl_m);
    end
    mode_m = 32'hA5A5_5A5A;
    wr(8'h00, mode_m);
    rd_chk("R5 mode", 8'h00, mode_m);
    v = $urandom; v[8] = 1'b0;
    pin_wr(v);
    rd_chk("R5 pin", 8'h08, pin_m);

    // R1 unmapped and misaligned
    rd_chk("R1 unmapped 0x10", 8'h10, 0);
    rd_chk("R1 unmapped 0xFC", 8'hFC, 0);
    rd_chk("R1 misaligned 0x05", 8'h05, 0);
    wr(8'h09, 32'hFFFF_FFFF);
    wr(8'h44, 32'h1234_5678);
    rd_chk("R1 pin after misaligned write", 8'h08, pin_m);
    rd_chk("R1 ctrl after unmapped write", 8'h04, ctrl_m);

    // R9 receive register read-only
    wr(8'h0C, 32'hDEAD_BEEF);
    rd_chk("R9 rx unchanged", 8'h0C, rx_m);

    // R7 rise with software mode off
    set_miso(1'b1);
    pin_pulse_off: begin
      pin_wr(pin_m | 32'h100);
      pin_wr(pin_m & ~32'h100);
    end
    rd_chk("R7 no shift in flash mode", 8'h0C, 32'd0);

    // enable software mode
    mode_m = 32'h0000_0001;
    wr(8'h00, mode_m);
    chk_pins("R3 after mode on");

    // R3 random pin patterns (random rises shift too)
    for (int i = 0; i < 24; i++) begin
      set_miso(1'($urandom));
      pin_wr($urandom);
      chk_pins("R3 pin pattern");
    end
    rd_chk("R6 rx after random pins", 8'h0C, rx_m);

    // R7 clock already high, then high again
    set_miso(1'b1);
    pin_wr(32'h0000_0100);
    v = rx_m;
    pin_wr(32'h0001_0101);
    pin_wr(32'h0002_0100);
    rd_chk("R7 high-to-high no shift", 8'h0C, v);
    pin_wr(32'h0);
    pin_wr(32'h0004_0001);
    rd_chk("R7 low-to-low no shift", 8'h0C, v);

    // R8 synchronizer depth
    set_miso(1'b0);
    pin_wr(32'h0);
    spi_miso = 1'b1;
    @(negedge clk);
    wr(8'h08, 32'h100);
    rd(8'h0C, got);
    chk("R8 edge two captures old level", {31'd0, got[0]}, 32'd0);
    wr(8'h08, 32'h0);
    spi_miso = 1'b0;
    repeat (2) @(negedge clk);
    wr(8'h08, 32'h100);
    rd(8'h0C, got);
    chk("R8 edge three captures new level", {31'd0, got[0]}, 32'd0);
    wr(8'h08, 32'h0);
    pin_m = 32'h0;
    rd(8'h0C, rx_m);

    // R6 mode-0 words of random length, MSB first
    for (int w = 0; w < 20; w++) begin
      int len;
      logic [31:0] tx, expw;
      len = (w == 0) ? 32 : (w == 1) ? 1 : 1 + int'($urandom % 32);
      tx = $urandom;
      expw = '0;
      for (int b = len - 1; b >= 0; b--) begin
        logic mi;
        mi = 1'($urandom);
        set_miso(mi);
        pin_wr(32'h0001_0000 | {31'd0, tx[b]});
        pin_wr(32'h0001_0100 | {31'd0, tx[b]});
        chk_pins("R3 mosi during word");
        expw = {expw[30:0], mi};
      end
      pin_wr(32'h0001_0000);
      rd_chk("R6 rx word", 8'h0C, rx_m);
      rd(8'h0C, got);
      chk("R6 latest bits", got & ((len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1)),
          (len == 32) ? expw : (expw & ((32'd1 << len) - 1)));
    end

    // R11 one-cycle read latency
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h04;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 rsp_valid after accept", {31'd0, rsp_valid}, 32'd1);
    chk("R11 rsp_data", rsp_data, ctrl_m);
    @(negedge clk);
    chk("R10 rsp drops when taken", {31'd0, rsp_valid}, 32'd0);

    // R10 back-pressure
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h04;
    @(posedge clk);
    @(negedge clk);
    v = $urandom;
    req_write = 1'b1; req_wdata = v;
    for (int k = 0; k < 3; k++) begin
      chk("R10 held valid", {31'd0, rsp_valid}, 32'd1);
      chk("R10 held data", rsp_data, ctrl_m);
      chk("R10 req stalled", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ctrl_m = v;
    chk("R10 released", {31'd0, rsp_valid}, 32'd0);
    rd_chk("R10 stalled write landed", 8'h04, ctrl_m);
    wr(8'h04, 32'h5);
    ctrl_m = 32'h5;
    chk("R10 write has no response", {31'd0, rsp_valid}, 32'd0);

    // R4 back to flash engine
    pin_wr(32'h0007_0001);
    mode_m = 32'h0;
    wr(8'h00, 32'h0);
    {fe_cs, fe_sck, fe_mosi} = 5'b01010;
    #1;
    chk_pins("R4 mode off");

    finish_run();
  end
endmodule